// File: doc/BRIEF.md
# Memory Request Picker with Hysteretic Write Drain

This block chooses, every clock cycle, which pending request of a memory controller queue should issue next. The queue itself lives outside; it presents one valid flag, one write flag, one row-hit flag and one age value per slot. The picker answers combinationally in the same cycle with a one-hot grant and the matching slot index. A larger age value means an older request.

In normal operation, requests that hit an open row go before requests that miss. Among requests with the same hit status, reads go before writes. Among equal candidates, the oldest request wins, and the lowest slot index breaks an exact tie. The block also keeps its own count of outstanding writes. The count goes up when the queue reports a new write and goes down when a write is granted.

When that count climbs above half the queue depth, the picker enters drain mode. In drain mode every valid write outranks every read, and row hits are preferred among the writes. Drain mode ends only when the count falls below a quarter of the depth, so the block does not flip in and out of the mode near a single threshold. The environment is expected to remove each granted slot before the next cycle, so every grant is treated as consumed.

Top module: `mreq_picker`

## Requirements
- R1: After reset the write count is 0 and drain_mode is 0. While no slot is valid, grant_valid is 0 and grant_oh is all zero.
- R2: grant_valid is 1 exactly when at least one slot is valid. grant_oh then has exactly one bit set, at position grant_idx, and that slot is valid.
- R3: Outside drain mode, a valid row-hit slot is always chosen over a row-miss slot, whatever their read/write type and ages.
- R4: Outside drain mode, between slots with the same row-hit status, a read (write flag 0) is chosen over a write (write flag 1).
- R5: Among slots of equal priority class, the slot with the largest age value wins. On equal age, the lowest index wins.
- R6: The write count rises by one on a cycle with enq_write=1 and no write granted. It falls by one on a cycle where a write is granted and enq_write=0. It is unchanged when both happen in the same cycle. The count saturates at 0 and at DEPTH.
- R7: drain_mode becomes 1 at the clock edge where the updated count exceeds DEPTH/2 (33 for DEPTH=64).
- R8: Once set, drain_mode stays 1 while the updated count is at least DEPTH/4. It clears at the edge where the count drops below DEPTH/4 (becomes 15 for DEPTH=64).
- R9: In drain mode, any valid write is chosen over any read, and among writes a row hit is chosen over a miss. A read is granted only when no write is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | DEPTH | Slot holds a pending request |
| ent_write | input | DEPTH | Slot request is a write (1) or a read (0) |
| ent_hit | input | DEPTH | Slot request targets the currently open row |
| ent_age | input | DEPTH*AGE_W | Per-slot age, slot i at bits [i*AGE_W +: AGE_W]; larger means older |
| enq_write | input | 1 | A new write entered the queue this cycle |
| grant_valid | output | 1 | A slot is granted this cycle |
| grant_oh | output | DEPTH | One-hot grant vector |
| grant_idx | output | $clog2(DEPTH) | Index of the granted slot |
| drain_mode | output | 1 | Write drain mode is active |

## Verification
On every cycle the assertions check these rules:
- the grant is one-hot and agrees with the index;
- a grant exists exactly when a slot is valid, and it points at a valid slot;
- a row hit always wins outside drain mode;
- a write always wins inside drain mode;
- the write count never goes past the depth and holds steady when an enqueue and a write grant coincide;
- drain mode only switches on above the high mark and only switches off below the low mark.

Some behaviour can only be shown by the bench's directed scenarios:
- age ordering and the lowest-index tie-break;
- read-over-write ordering within one hit level;
- the exact cycle on which drain mode starts and ends after a counted run of enqueues and write grants.

The bench also compares long pseudo-random slot patterns against its own priority model.

// File: rtl/mreq_pkg.sv
package mreq_pkg;

  // Two-bit priority class; a larger value is preferred.
  // Normal mode: row hit dominates, then read over write.
  // Drain mode:  write dominates, then row hit.
  function automatic logic [1:0] rank_of(logic drain, logic is_wr, logic hit);
    return drain ? {is_wr, hit} : {hit, ~is_wr};
  endfunction

  // Hysteresis: enter above the high mark, leave only below the low mark.
  function automatic logic hyst_next(logic cur, logic over_hi, logic under_lo);
    return cur ? ~under_lo : over_hi;
  endfunction

endpackage

// File: rtl/mreq_key_gen.sv
module mreq_key_gen
  import mreq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AGE_W = 8,
  localparam int KW = 3 + AGE_W
) (
  input  logic                   drain,
  input  logic [DEPTH-1:0]       ent_valid,
  input  logic [DEPTH-1:0]       ent_write,
  input  logic [DEPTH-1:0]       ent_hit,
  input  logic [DEPTH*AGE_W-1:0] ent_age,
  output logic [DEPTH*KW-1:0]    keys
);

  // Key layout: {valid, class rank, age}; plain magnitude compare orders them.
  for (genvar i = 0; i < DEPTH; i++) begin : g_key
    assign keys[i*KW +: KW] = {ent_valid[i],
                               rank_of(drain, ent_write[i], ent_hit[i]),
                               ent_age[i*AGE_W +: AGE_W]};
  end

endmodule

// File: rtl/mreq_pick_tree.sv
module mreq_pick_tree #(
  parameter int N  = 64,
  parameter int KW = 11,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*KW-1:0] keys,
  output logic [KW-1:0]   win_key,
  output logic [IW-1:0]   win_idx
);

  // Heap-ordered binary tree: node n has children 2n+1 (lower indices) and 2n+2.
  logic [KW-1:0] nk [2*N-1];
  logic [IW-1:0] ni [2*N-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign nk[N-1+i] = keys[i*KW +: KW];
    assign ni[N-1+i] = IW'(i);
  end

  // Left side wins ties, which gives the lowest index on equal keys.
  for (genvar n = 0; n < N-1; n++) begin : g_node
    logic take_left;
    assign take_left = (nk[2*n+1] >= nk[2*n+2]);
    assign nk[n] = take_left ? nk[2*n+1] : nk[2*n+2];
    assign ni[n] = take_left ? ni[2*n+1] : ni[2*n+2];
  end

  assign win_key = nk[0];
  assign win_idx = ni[0];

endmodule

// File: rtl/mreq_wr_tracker.sv
module mreq_wr_tracker
  import mreq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] wr_cnt,
  output logic          drain
);

  localparam logic [CW-1:0] HI_MARK = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LO_MARK = CW'(DEPTH / 4);
  localparam logic [CW-1:0] MAX_CNT = CW'(DEPTH);

  function automatic logic [CW-1:0] step_count(logic [CW-1:0] c, logic up, logic dn);
    if (up && !dn && c < MAX_CNT) return c + 1'b1;
    if (dn && !up && c != '0)     return c - 1'b1;
    return c;
  endfunction

  logic [CW-1:0] cnt_d;
  logic          drain_d;

  assign cnt_d   = step_count(wr_cnt, inc, dec);
  assign drain_d = hyst_next(drain, cnt_d > HI_MARK, cnt_d < LO_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      drain  <= 1'b0;
    end else begin
      wr_cnt <= cnt_d;
      drain  <= drain_d;
    end
  end

endmodule

// File: rtl/mreq_picker.sv
module mreq_picker #(
  parameter int DEPTH = 64,
  parameter int AGE_W = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int KW = 3 + AGE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEPTH-1:0]       ent_valid,
  input  logic [DEPTH-1:0]       ent_write,
  input  logic [DEPTH-1:0]       ent_hit,
  input  logic [DEPTH*AGE_W-1:0] ent_age,
  input  logic                   enq_write,
  output logic                   grant_valid,
  output logic [DEPTH-1:0]       grant_oh,
  output logic [IW-1:0]          grant_idx,
  output logic                   drain_mode
);

  logic [DEPTH*KW-1:0] keys;
  logic [KW-1:0]       win_key;
  logic [IW-1:0]       win_idx;
  logic                wr_inc;   // write count event: new write queued
  logic                wr_dec;   // write count event: write granted
  logic [CW-1:0]       wr_cnt;

  mreq_key_gen #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_keys (
    .drain     (drain_mode),
    .ent_valid (ent_valid),
    .ent_write (ent_write),
    .ent_hit   (ent_hit),
    .ent_age   (ent_age),
    .keys      (keys)
  );

  mreq_pick_tree #(.N(DEPTH), .KW(KW)) u_tree (
    .keys    (keys),
    .win_key (win_key),
    .win_idx (win_idx)
  );

  assign grant_valid = win_key[KW-1];
  assign grant_idx   = win_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_oh
    assign grant_oh[i] = grant_valid && (win_idx == IW'(i));
  end

  assign wr_inc = enq_write;
  assign wr_dec = grant_valid && ent_write[win_idx];

  mreq_wr_tracker #(.DEPTH(DEPTH)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (wr_inc),
    .dec    (wr_dec),
    .wr_cnt (wr_cnt),
    .drain  (drain_mode)
  );

endmodule

// File: rtl/mreq_picker_chk.sv
module mreq_picker_chk #(
  parameter int DEPTH = 64,
  parameter int AGE_W = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DEPTH-1:0] ent_valid,
  input logic [DEPTH-1:0] ent_write,
  input logic [DEPTH-1:0] ent_hit,
  input logic             enq_write,
  input logic             grant_valid,
  input logic [DEPTH-1:0] grant_oh,
  input logic [IW-1:0]    grant_idx,
  input logic             drain_mode,
  input logic [CW-1:0]    wr_cnt
);

  localparam logic [CW-1:0] HI_MARK = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LO_MARK = CW'(DEPTH / 4);
  localparam int            AGE_BITS = AGE_W;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh) && (grant_valid == (grant_oh != '0)));

  p_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (ent_valid != '0));

  p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_oh[grant_idx] && ent_valid[grant_idx]));

  p_hit_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_mode && (ent_valid & ent_hit) != '0) |-> ent_hit[grant_idx]);

  p_write_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_mode && (ent_valid & ent_write) != '0) |-> ent_write[grant_idx]);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= CW'(DEPTH));

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_write && grant_valid && ent_write[grant_idx]) |=> $stable(wr_cnt));

  p_drain_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_mode) |-> (wr_cnt > HI_MARK));

  p_drain_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_mode) |-> (wr_cnt < LO_MARK));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid == '0) |-> (!grant_valid && AGE_BITS > 0));

endmodule

bind mreq_picker mreq_picker_chk #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_chk (.*);

// File: tb/test_mreq_picker.sv
module test_mreq_picker;

  localparam int DEPTH = 64;
  localparam int AGE_W = 8;
  localparam time CLK_P = 8ns;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [DEPTH-1:0]       v = '0, w = '0, h = '0;
  logic [DEPTH*AGE_W-1:0] ag = '0;
  logic                   enq = 1'b0;
  logic                   grant_valid;
  logic [DEPTH-1:0]       grant_oh;
  logic [5:0]             grant_idx;
  logic                   drain_mode;

  int  nchk = 0;
  int  nerr = 0;
  int  mcnt = 0;
  bit  mdrain = 1'b0;
  bit  finished = 1'b0;
  logic [31:0] rs = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  mreq_picker #(.DEPTH(DEPTH), .AGE_W(AGE_W)) i_mreq_picker (
    .clk (clk), .rst_n (rst_n),
    .ent_valid (v), .ent_write (w), .ent_hit (h), .ent_age (ag),
    .enq_write (enq),
    .grant_valid (grant_valid), .grant_oh (grant_oh),
    .grant_idx (grant_idx), .drain_mode (drain_mode)
  );

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_all();
    v = '0; w = '0; h = '0; ag = '0;
  endtask

  task automatic set_ent(int i, bit iw, bit ih, int a);
    v[i] = 1'b1; w[i] = iw; h[i] = ih; ag[i*AGE_W +: AGE_W] = a[AGE_W-1:0];
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  // Priority model: explicit score per mode, then age, then first index.
  function automatic int exp_idx(bit dr);
    int best = -1;
    int bs = -1;
    int ba = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (v[i]) begin
        int sc = dr ? (int'(w[i]) * 2 + int'(h[i])) : (int'(h[i]) * 2 + int'(!w[i]));
        int a  = int'(ag[i*AGE_W +: AGE_W]);
        if (sc > bs || (sc == bs && a > ba)) begin
          best = i; bs = sc; ba = a;
        end
      end
    end
    return best;
  endfunction

  // Called at a falling edge with inputs already set; ends at the next falling edge.
  task automatic step(string req, int lit);
    int  e;
    bit  dec;
    #1;
    e = exp_idx(mdrain);
    chk(req, "grant_valid", int'(grant_valid), int'(e >= 0));
    if (e >= 0) begin
      chk(req, "grant_idx", int'(grant_idx), e);
      chk(req, "grant_oh", int'(grant_oh == (64'd1 << e)), 1);
    end else begin
      chk(req, "grant_oh_zero", int'(grant_oh == '0), 1);
    end
    if (lit >= 0) chk(req, "grant_idx_literal", int'(grant_idx), lit);
    @(posedge clk);
    dec = (e >= 0) && w[e];
    if (enq && !dec && mcnt < DEPTH) mcnt++;
    else if (dec && !enq && mcnt > 0) mcnt--;
    if (mcnt > DEPTH/2) mdrain = 1'b1;
    else if (mcnt < DEPTH/4) mdrain = 1'b0;
    @(negedge clk);
    chk(req, "drain_mode", int'(drain_mode), int'(mdrain));
  endtask

  task automatic t_reset();
    chk("R1", "drain in reset", int'(drain_mode), 0);
    chk("R1", "grant_valid idle", int'(grant_valid), 0);
    step("R1", -1);
  endtask

  task automatic t_hit_first();
    clr_all();
    set_ent(5, 1'b0, 1'b0, 200);
    set_ent(40, 1'b1, 1'b1, 1);
    step("R3", 40);
    clr_all();
  endtask

  task automatic t_read_first();
    clr_all();
    set_ent(10, 1'b1, 1'b1, 250);
    set_ent(20, 1'b0, 1'b1, 3);
    step("R4", 20);
    clr_all();
    set_ent(30, 1'b1, 1'b0, 99);
    set_ent(31, 1'b0, 1'b0, 2);
    step("R4", 31);
    clr_all();
  endtask

  task automatic t_age();
    clr_all();
    set_ent(3, 1'b0, 1'b1, 7);
    set_ent(9, 1'b0, 1'b1, 90);
    set_ent(50, 1'b0, 1'b1, 90);
    step("R5", 9);
    v[9] = 1'b0;
    step("R5", 50);
    clr_all();
  endtask

  task automatic t_none();
    clr_all();
    step("R2", -1);
    chk("R2", "no grant when empty", int'(grant_valid), 0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 60; k++) begin
      v = {rnd(), rnd()};
      w = {rnd(), rnd()};
      h = {rnd(), rnd()};
      for (int i = 0; i < DEPTH; i++) ag[i*AGE_W +: AGE_W] = rnd()[AGE_W-1:0];
      if (k % 7 == 0) v = v & {rnd(), rnd()} & {rnd(), rnd()};
      step("R2", -1);
    end
    clr_all();
  endtask

  task automatic t_drain();
    clr_all();
    enq = 1'b1;
    for (int k = 0; k < 32; k++) step("R6", -1);
    chk("R7", "drain off at 32 writes", int'(drain_mode), 0);
    step("R7", -1);
    chk("R7", "drain on at 33 writes", int'(drain_mode), 1);
    enq = 1'b0;
    set_ent(2, 1'b0, 1'b1, 255);
    set_ent(60, 1'b1, 1'b0, 200);
    set_ent(61, 1'b1, 1'b1, 0);
    step("R9", 61);
    enq = 1'b1;
    for (int k = 0; k < 5; k++) step("R6", 61);
    enq = 1'b0;
    v[61] = 1'b0;
    for (int k = 0; k < 16; k++) step("R8", 60);
    chk("R8", "drain held at 16", int'(drain_mode), 1);
    step("R8", 60);
    chk("R8", "drain off at 15", int'(drain_mode), 0);
    step("R3", 2);
    clr_all();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "drain during reset", int'(drain_mode), 0);
    rst_n = 1'b1;
    t_reset();
    t_hit_first();
    t_read_first();
    t_age();
    t_none();
    t_random();
    t_drain();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule